// File: doc/BRIEF.md
# Interrupt Source Gating Unit

This block holds the configuration and pending state of a small bank of interrupt sources and decides, source by source, whether a request may be offered to a destination. Each source owns two 32-bit registers, a configuration word and a destination word. Software reaches both through a plain register port: one write strobe, an address and combinational read data. Raw request lines arrive unsynchronised to no protocol beyond the clock. Each line is treated as level- or edge-sensitive according to its own configuration.

When a source is eligible, the block raises a one-cycle delivery strobe for it. It also presents that source's priority, vector and destination mask, all valid alongside the strobe. Arbitration between sources, acknowledge handling and distributed delivery belong to downstream logic. That logic returns a per-source clear-activity pulse once it has finished with a request. Only directed delivery is supported: the destination mask is passed through as stored.

Configuration word layout: bit 31 blocks the source (mask), bit 30 is the read-only activity flag, bit 22 selects level sensing when 1 and edge sensing when 0, bits 20:16 hold a 5-bit priority, and the low VEC_W bits hold the vector. Address bit 0 selects the configuration word (0) or the destination word (1). The remaining upper address bits give the source index.

Top module: `intr_src_gate`

## Requirements
- R1: After reset every configuration word reads 0xA0000000, every destination word reads 0, and no delivery strobe is raised.
- R2: A source is never delivered while its mask bit (bit 31) is 1, while its priority field (bits 20:16) is 0, while its activity bit (bit 30) is 1, or while its destination word is 0.
- R3: A configuration write stores every written bit except bit 30, which keeps its current activity value; reads return the stored word unchanged.
- R4: A destination write keeps bits 31:30 and bits NUM_DST-1:0 of the written data and stores zero in every other bit.
- R5: For a level source (bit 22 = 1) pending follows the input; while the input is low the activity bit is cleared in the next cycle.
- R6: For an edge source (bit 22 = 0) a rising input sets pending, which persists after the input falls and is cleared when the source is delivered.
- R7: Delivery is evaluated from registered state: the strobe appears in the cycle after the input change or register write that makes the source eligible.
- R8: A delivery sets the activity bit in the next cycle, so the strobe lasts exactly one cycle; a clear-activity pulse clears the bit, allowing a still-pending source to be delivered again.
- R9: While a source's strobe is high, its priority (bits 20:16), vector (bits VEC_W-1:0) and destination word appear on the per-source output slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_SRC | Raw request line per source |
| ack_clr | input | NUM_SRC | Clear-activity pulse per source from the delivery logic |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NUM_SRC)+1 | {source index, word select}; select 0 = configuration, 1 = destination |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| deliver | output | NUM_SRC | One-cycle delivery strobe per source |
| dlv_prio | output | NUM_SRC*5 | Priority of each source, 5 bits per slice |
| dlv_vec | output | NUM_SRC*VEC_W | Vector of each source |
| dlv_dest | output | NUM_SRC*NUM_DST | Destination mask of each source |

## Verification
The assertions take for granted that the clear-activity pulse and a request line are the only things that touch a source's activity apart from delivery. They also assume that the source index in reg_addr is always below NUM_SRC. The stimulus drives every input one nanosecond after the rising edge, so each change is seen by exactly one edge. It only addresses implemented sources. It resets a source's stale edge pending state between sweep points by flipping it to level sensing with the line low. It never pulses clear-activity in the cycle that would overlap a delivery strobe it is checking.

// File: rtl/intr_gate_pkg.sv
package intr_gate_pkg;

    localparam int CFG_W        = 32;
    localparam int MASK_BIT     = 31;
    localparam int ACT_BIT      = 30;
    localparam int SENSE_BIT    = 22;
    localparam int PRIO_LSB     = 16;
    localparam int PRIO_W       = 5;
    localparam logic [CFG_W-1:0] CFG_RESET  = 32'hA000_0000;
    localparam logic [CFG_W-1:0] DEST_HI    = 32'hC000_0000;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [CFG_W-1:0] dest;
        logic             pend;
        logic             in_q;
    } gate_state_t;

endpackage

// File: rtl/intr_gate_wrdec.sv
module intr_gate_wrdec #(
    parameter int NUM_SRC = 4,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_SRC-1:0] wr_cfg,
    output logic [NUM_SRC-1:0] wr_dest
);

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:1];

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
            logic hit;
            assign hit        = wr_en && (idx == IDX_W'(g));
            assign wr_cfg[g]  = hit && !addr[0];
            assign wr_dest[g] = hit &&  addr[0];
        end
    endgenerate

endmodule

// File: rtl/intr_gate_rdmux.sv
module intr_gate_rdmux #(
    parameter int NUM_SRC = 4,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NUM_SRC*32-1:0] cfg_flat,
    input  logic [NUM_SRC*32-1:0] dest_flat,
    output logic [31:0]           rdata
);

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:1];

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (idx == IDX_W'(i)) begin
                rdata = addr[0] ? dest_flat[i*32 +: 32] : cfg_flat[i*32 +: 32];
            end
        end
    end

endmodule

// File: rtl/intr_gate_src.sv
module intr_gate_src
    import intr_gate_pkg::*;
#(
    parameter int NUM_DST = 2,
    parameter int VEC_W   = 8,
    localparam logic [CFG_W-1:0] DEST_KEEP = DEST_HI | CFG_W'((64'd1 << NUM_DST) - 64'd1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_in,
    input  logic               ack_clr,
    input  logic               wr_cfg,
    input  logic               wr_dest,
    input  logic [CFG_W-1:0]   wdata,
    output logic [CFG_W-1:0]   cfg_o,
    output logic [CFG_W-1:0]   dest_o,
    output logic               deliver,
    output logic [PRIO_W-1:0]  prio,
    output logic [VEC_W-1:0]   vec,
    output logic [NUM_DST-1:0] dest_mask
);

    gate_state_t s_d, s_q;

    logic level, rise, eligible, act;

    always_comb begin
        s_d      = s_q;
        level    = s_q.cfg[SENSE_BIT];
        rise     = irq_in && !s_q.in_q;
        eligible = s_q.pend
                && !s_q.cfg[MASK_BIT]
                && (s_q.cfg[PRIO_LSB +: PRIO_W] != '0)
                && !s_q.cfg[ACT_BIT]
                && (s_q.dest != '0);

        s_d.in_q = irq_in;

        act = s_q.cfg[ACT_BIT];
        if (ack_clr)          act = 1'b0;
        if (eligible)         act = 1'b1;
        if (level && !irq_in) act = 1'b0;

        if (level) s_d.pend = irq_in;
        else       s_d.pend = (s_q.pend && !eligible) || rise;

        if (wr_cfg) s_d.cfg = wdata;
        s_d.cfg[ACT_BIT] = act;

        if (wr_dest) s_d.dest = wdata & DEST_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cfg  <= CFG_RESET;
            s_q.dest <= '0;
            s_q.pend <= 1'b0;
            s_q.in_q <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o     = s_q.cfg;
    assign dest_o    = s_q.dest;
    assign deliver   = eligible;
    assign prio      = s_q.cfg[PRIO_LSB +: PRIO_W];
    assign vec       = s_q.cfg[VEC_W-1:0];
    assign dest_mask = s_q.dest[NUM_DST-1:0];

endmodule

// File: rtl/intr_src_gate.sv
module intr_src_gate
    import intr_gate_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int NUM_DST = 2,
    parameter int VEC_W   = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         irq_in,
    input  logic [NUM_SRC-1:0]         ack_clr,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    output logic [NUM_SRC-1:0]         deliver,
    output logic [NUM_SRC*PRIO_W-1:0]  dlv_prio,
    output logic [NUM_SRC*VEC_W-1:0]   dlv_vec,
    output logic [NUM_SRC*NUM_DST-1:0] dlv_dest
);

    logic [NUM_SRC-1:0]    wr_cfg, wr_dest;
    logic [NUM_SRC*32-1:0] cfg_flat, dest_flat;

    intr_gate_wrdec #(.NUM_SRC(NUM_SRC)) u_wrdec (
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wr_cfg  (wr_cfg),
        .wr_dest (wr_dest)
    );

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            intr_gate_src #(.NUM_DST(NUM_DST), .VEC_W(VEC_W)) u_src (
                .clk       (clk),
                .rst_n     (rst_n),
                .irq_in    (irq_in[g]),
                .ack_clr   (ack_clr[g]),
                .wr_cfg    (wr_cfg[g]),
                .wr_dest   (wr_dest[g]),
                .wdata     (reg_wdata),
                .cfg_o     (cfg_flat[g*32 +: 32]),
                .dest_o    (dest_flat[g*32 +: 32]),
                .deliver   (deliver[g]),
                .prio      (dlv_prio[g*PRIO_W +: PRIO_W]),
                .vec       (dlv_vec[g*VEC_W +: VEC_W]),
                .dest_mask (dlv_dest[g*NUM_DST +: NUM_DST])
            );
        end
    endgenerate

    intr_gate_rdmux #(.NUM_SRC(NUM_SRC)) u_rdmux (
        .addr      (reg_addr),
        .cfg_flat  (cfg_flat),
        .dest_flat (dest_flat),
        .rdata     (reg_rdata)
    );

endmodule

// File: rtl/intr_gate_chk.sv
module intr_gate_chk
    import intr_gate_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int NUM_DST = 2,
    localparam logic [31:0] KEEP = DEST_HI | 32'((64'd1 << NUM_DST) - 64'd1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SRC-1:0]         irq_in,
    input logic [NUM_SRC-1:0]         deliver,
    input logic [NUM_SRC*PRIO_W-1:0]  dlv_prio,
    input logic [NUM_SRC*32-1:0]      cfg_flat,
    input logic [NUM_SRC*32-1:0]      dest_flat
);

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
            p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
                deliver[g] |-> (!cfg_flat[g*32 + MASK_BIT]
                                && dlv_prio[g*PRIO_W +: PRIO_W] != '0
                                && dest_flat[g*32 +: 32] != '0));

            p_dest_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (dest_flat[g*32 +: 32] & ~KEEP) == '0);

            p_level_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_flat[g*32 + SENSE_BIT] && !irq_in[g]) |=> !cfg_flat[g*32 + ACT_BIT]);

            p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
                deliver[g] |=> !deliver[g]);

            p_act_from_deliver_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(cfg_flat[g*32 + ACT_BIT]) |-> $past(deliver[g]));
        end
    endgenerate

endmodule

bind intr_src_gate intr_gate_chk #(.NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .deliver   (deliver),
    .dlv_prio  (dlv_prio),
    .cfg_flat  (cfg_flat),
    .dest_flat (dest_flat)
);

// File: tb/intr_src_gate_bench.sv
`timescale 1ns/1ps
module intr_src_gate_bench;

    localparam int NS = 4;
    localparam int ND = 2;
    localparam int VW = 8;
    localparam int AW = $clog2(NS) + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   irq_in = '0;
    logic [NS-1:0]   ack_clr = '0;
    logic            reg_wr = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NS-1:0]   deliver;
    logic [NS*5-1:0] dlv_prio;
    logic [NS*VW-1:0] dlv_vec;
    logic [NS*ND-1:0] dlv_dest;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    intr_src_gate #(.NUM_SRC(NS), .NUM_DST(ND), .VEC_W(VW)) u_intr_src_gate (
        .clk, .rst_n, .irq_in, .ack_clr, .reg_wr, .reg_addr, .reg_wdata,
        .reg_rdata, .deliver, .dlv_prio, .dlv_vec, .dlv_dest
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int s, input bit sel, input logic [31:0] d);
        reg_addr  = AW'({s[AW-2:0], sel});
        reg_wdata = d;
        reg_wr    = 1'b1;
        tick();
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int s, input bit sel, output logic [31:0] d);
        reg_addr = AW'({s[AW-2:0], sel});
        #0.5;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] mkcfg(bit m, bit lvl, int p, int v);
        return (32'(m) << 31) | (32'(lvl) << 22) | (32'(p) << 16) | 32'(v & 8'hFF);
    endfunction

    task automatic pulse_ack(input int s);
        ack_clr[s] = 1'b1;
        tick();
        ack_clr[s] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        for (int s = 0; s < NS; s++) begin
            rd(s, 0, r); chk("R1 cfg reset", r, 32'hA000_0000);
            rd(s, 1, r); chk("R1 dest reset", r, 32'h0);
        end
        chk("R1 no deliver", 32'(deliver), 32'h0);

        // R4 destination write masking
        wr(1, 1, 32'hFFFF_FFFF);
        rd(1, 1, r); chk("R4 dest keep", r, 32'hC000_0003);
        wr(1, 1, 32'h3FFF_FFFC);
        rd(1, 1, r); chk("R4 dest drop", r, 32'h0);

        // R3 activity bit not writable while clear
        wr(2, 0, 32'h7FFF_FFFF);
        rd(2, 0, r); chk("R3 act write ignored", r, 32'h3FFF_FFFF);

        // R2/R5/R6/R7/R8/R9 sweep over gating combinations
        for (int s = 0; s < NS; s++)
            for (int m = 0; m < 2; m++)
                for (int pi = 0; pi < 2; pi++)
                    for (int d = 0; d < 4; d++)
                        for (int lv = 0; lv < 2; lv++) begin
                            int p = pi ? (5 + s) : 0;
                            int v = s * 32 + m * 16 + d * 4 + lv;
                            bit ex = (m == 0) && (p != 0) && (d != 0);
                            irq_in[s] = 1'b0;
                            wr(s, 0, mkcfg(1, 1, 1, 0));
                            pulse_ack(s);
                            wr(s, 1, 32'(d));
                            wr(s, 0, mkcfg(m[0], lv[0], p, v));
                            chk("R7 no deliver before input", 32'(deliver[s]), 32'h0);
                            irq_in[s] = 1'b1;
                            tick();
                            chk("R2 gate", 32'(deliver[s]), 32'(ex));
                            chk("R2 others quiet", 32'(deliver & ~(NS'(1) << s)), 32'h0);
                            if (ex) begin
                                chk("R9 prio", 32'(dlv_prio[s*5 +: 5]), 32'(p));
                                chk("R9 vec", 32'(dlv_vec[s*VW +: VW]), 32'(v & 8'hFF));
                                chk("R9 dest", 32'(dlv_dest[s*ND +: ND]), 32'(d));
                            end
                            tick();
                            chk("R8 single strobe", 32'(deliver[s]), 32'h0);
                            rd(s, 0, r);
                            chk("R8 act set", 32'(r[30]), 32'(ex));
                            chk("R3 readback", r & 32'hBFFF_FFFF, mkcfg(m[0], lv[0], p, v));
                            irq_in[s] = 1'b0;
                            tick();
                            rd(s, 0, r);
                            chk("R5/R6 act after drop", 32'(r[30]), 32'(ex && lv == 0));
                            chk("R2 act blocks", 32'(deliver[s]), 32'h0);
                        end

        // R3 activity preserved by write, R8 ack and redelivery (level)
        irq_in[0] = 1'b0;
        wr(0, 0, mkcfg(1, 1, 1, 0));
        wr(0, 1, 32'h1);
        wr(0, 0, mkcfg(0, 1, 7, 8'h5A));
        irq_in[0] = 1'b1;
        tick();
        chk("R5 level deliver", 32'(deliver[0]), 32'h1);
        tick();
        wr(0, 0, mkcfg(0, 1, 7, 8'h5B));
        rd(0, 0, r); chk("R3 act kept on write", r, mkcfg(0, 1, 7, 8'h5B) | 32'h4000_0000);
        chk("R2 active holds off", 32'(deliver[0]), 32'h0);
        pulse_ack(0);
        chk("R8 redeliver after ack", 32'(deliver[0]), 32'h1);
        tick();
        irq_in[0] = 1'b0;
        tick();
        rd(0, 0, r); chk("R5 level drop clears act", 32'(r[30]), 32'h0);
        chk("R5 no deliver when low", 32'(deliver[0]), 32'h0);

        // R6 edge pending held while masked; R7 delivery after unmask write
        wr(3, 0, mkcfg(1, 1, 1, 0));
        wr(3, 1, 32'h2);
        wr(3, 0, mkcfg(1, 0, 9, 8'h33));
        irq_in[3] = 1'b1; tick();
        irq_in[3] = 1'b0; tick(); tick();
        chk("R6 masked no deliver", 32'(deliver[3]), 32'h0);
        wr(3, 0, mkcfg(0, 0, 9, 8'h33));
        chk("R7 deliver after write", 32'(deliver[3]), 32'h1);
        chk("R9 vec edge", 32'(dlv_vec[3*VW +: VW]), 32'h33);
        tick();
        pulse_ack(3);
        tick();
        chk("R6 pending cleared by delivery", 32'(deliver[3]), 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule